// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter with Preset

This block is a binary counter in which every bit changes together on the rising clock edge. Three controls set what happens at each edge. An active-low clear takes first priority, then an active-low parallel load, then counting, and the counter holds when none of these applies. There are two count enables. The first, the count enable, only gates the increment. The second, the carry enable, gates the increment as well and also reaches the carry output through logic alone, with no register on the way. Because of this, the carry output of one stage can drive the carry enable of the next stage with no added delay.

The top module builds a wide counter from `STAGES` stages of `STAGE_W` bits each. All stages share the count enable. Each stage above the lowest gets its carry enable from the stages below it, either as a ripple from the previous stage's carry or as a look-ahead term, chosen by a parameter. Next to the counter, the top module holds a worked modulus example. This is a second chain of the same width that decodes the count `MODULUS-1` and pulls its own synchronous clear low for that one edge. It therefore steps through 0 to `MODULUS-1` and then back to 0.

Top module: `casc_counter_top`

## Requirements
- R1: When `clear_n` is low at a rising edge, `count` and `wrap_count` become 0, whatever the levels on `load_n`, `cnt_en` and `carry_en`.
- R2: When `clear_n` is high and `load_n` is low at a rising edge, `count` takes `data_in`, whatever the levels on the two enables.
- R3: When `clear_n` and `load_n` are high and both `cnt_en` and `carry_en` are high, `count` goes up by one at the edge.
- R4: When `clear_n` and `load_n` are high and either enable is low, `count` keeps its value across the edge.
- R5: An increment from all ones gives 0. For example, a 4-bit stage preset to 12 counts 13, 14, 15, 0, 1, 2.
- R6: `carry_out` equals `carry_en` AND (every bit of `count` is 1). It follows `carry_en` within the same cycle, with no clock edge.
- R7: The chained stages act as one `STAGE_W*STAGES`-bit counter. A stage above the lowest advances only on the edge where every bit below it is 1. For example, 0x0F becomes 0x10.
- R8: `wrap_count` steps 0, 1, … `MODULUS-1`, 0 on edges where both enables are high, and holds otherwise, including while it is at `MODULUS-1`. It never reaches `MODULUS` or more, and `load_n` has no effect on it.
- R9: While the counter runs without a break, `carry_out` is high for exactly one cycle, the cycle in which `count` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable; gates the increment only |
| carry_en | input | 1 | Carry enable; gates the increment and `carry_out` |
| data_in | input | STAGE_W*STAGES | Preset value |
| count | output | STAGE_W*STAGES | Counter value |
| carry_out | output | 1 | Terminal-count carry of the last stage |
| wrap_count | output | STAGE_W*STAGES | Value of the modulus-`MODULUS` example counter |

## Verification
The bench builds two copies of the block. The first has two 4-bit stages with a ripple carry and a modulus of 11. It covers the carry crossing from the low nibble into the high nibble, the wrap from 0xFF to 0x00, and a modulus that is not a power of two, held at its last value. The second has a single 4-bit stage with look-ahead selected and a modulus of 5. It covers the 12 → 2 wrap sequence and a decode of a small modulus in the same run.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } cnt_op_e;

   // Priority: clear, then load, then count (both enables), else hold.
   function automatic cnt_op_e pick_op(input logic clear_n, input logic load_n,
                                       input logic en_a, input logic en_b);
      if (!clear_n)          return OP_CLEAR;
      else if (!load_n)      return OP_LOAD;
      else if (en_a && en_b) return OP_COUNT;
      else                   return OP_HOLD;
   endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
   import cnt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clear_n,
   input  logic         load_n,
   input  logic         cnt_en,
   input  logic         carry_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         tc
);

   if (W < 1) begin : g_bad_w
      $error("cnt_stage: W must be at least 1");
   end

   logic [W-1:0] q_r;
   cnt_op_e      op;

   assign op = pick_op(clear_n, load_n, cnt_en, carry_en);

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q_r <= '0;
         OP_LOAD:  q_r <= d;
         OP_COUNT: q_r <= q_r + 1'b1;
         default:  q_r <= q_r;
      endcase
   end

   assign q  = q_r;
   // carry enable reaches tc without a register
   assign tc = carry_en & (&q_r);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
   parameter int W         = 4,
   parameter int N         = 2,
   parameter bit LOOKAHEAD = 1'b0,
   localparam int TW       = W * N
) (
   input  logic          clk,
   input  logic          clear_n,
   input  logic          load_n,
   input  logic          cnt_en,
   input  logic          carry_en,
   input  logic [TW-1:0] d,
   output logic [TW-1:0] q,
   output logic          tc
);

   if (N < 1) begin : g_bad_n
      $error("cnt_chain: N must be at least 1");
   end

   logic [N-1:0] st_en;
   logic [N-1:0] st_tc;

   for (genvar i = 0; i < N; i++) begin : g_st
      if (i == 0) begin : g_first
         assign st_en[i] = carry_en;
      end else if (LOOKAHEAD) begin : g_la
         assign st_en[i] = carry_en & (&q[i*W-1:0]);
      end else begin : g_rip
         assign st_en[i] = st_tc[i-1];
      end

      cnt_stage #(.W(W)) u_stage (
         .clk      (clk),
         .clear_n  (clear_n),
         .load_n   (load_n),
         .cnt_en   (cnt_en),
         .carry_en (st_en[i]),
         .d        (d[i*W +: W]),
         .q        (q[i*W +: W]),
         .tc       (st_tc[i])
      );
   end

   if (LOOKAHEAD) begin : g_la_sink
      logic unused_tc;
      assign unused_tc = ^st_tc;
   end

   assign tc = st_tc[N-1];

endmodule

// File: rtl/cnt_modwrap.sv
module cnt_modwrap #(
   parameter int W         = 4,
   parameter int N         = 2,
   parameter int MODULUS   = 11,
   parameter bit LOOKAHEAD = 1'b0,
   localparam int TW       = W * N
) (
   input  logic          clk,
   input  logic          clear_n,
   input  logic          cnt_en,
   input  logic          carry_en,
   output logic [TW-1:0] q
);

   localparam logic [TW-1:0] LAST = TW'(MODULUS - 1);

   logic clr_int;
   logic unused_tc;

   if (MODULUS == (1 << TW)) begin : g_natural
      assign clr_int = clear_n;
   end else begin : g_decode
      // clear on the edge that would step past LAST
      assign clr_int = clear_n & ~(cnt_en & carry_en & (q == LAST));
   end

   cnt_chain #(.W(W), .N(N), .LOOKAHEAD(LOOKAHEAD)) u_chain (
      .clk      (clk),
      .clear_n  (clr_int),
      .load_n   (1'b1),
      .cnt_en   (cnt_en),
      .carry_en (carry_en),
      .d        ('0),
      .q        (q),
      .tc       (unused_tc)
   );

endmodule

// File: rtl/casc_counter_top.sv
module casc_counter_top #(
   parameter int STAGE_W   = 4,
   parameter int STAGES    = 2,
   parameter int MODULUS   = 11,
   parameter bit LOOKAHEAD = 1'b0,
   localparam int TOTAL_W  = STAGE_W * STAGES
) (
   input  logic               clk,
   input  logic               clear_n,
   input  logic               load_n,
   input  logic               cnt_en,
   input  logic               carry_en,
   input  logic [TOTAL_W-1:0] data_in,
   output logic [TOTAL_W-1:0] count,
   output logic               carry_out,
   output logic [TOTAL_W-1:0] wrap_count
);

   if (STAGE_W < 1 || STAGES < 1) begin : g_bad_shape
      $error("casc_counter_top: STAGE_W and STAGES must be at least 1");
   end
   if (TOTAL_W > 30) begin : g_bad_total
      $error("casc_counter_top: total width above 30 bits not supported");
   end
   if (MODULUS < 2 || MODULUS > (1 << TOTAL_W)) begin : g_bad_mod
      $error("casc_counter_top: MODULUS out of range for the width");
   end

   cnt_chain #(.W(STAGE_W), .N(STAGES), .LOOKAHEAD(LOOKAHEAD)) u_main (
      .clk      (clk),
      .clear_n  (clear_n),
      .load_n   (load_n),
      .cnt_en   (cnt_en),
      .carry_en (carry_en),
      .d        (data_in),
      .q        (count),
      .tc       (carry_out)
   );

   cnt_modwrap #(.W(STAGE_W), .N(STAGES), .MODULUS(MODULUS),
                 .LOOKAHEAD(LOOKAHEAD)) u_wrap (
      .clk      (clk),
      .clear_n  (clear_n),
      .cnt_en   (cnt_en),
      .carry_en (carry_en),
      .q        (wrap_count)
   );

endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
   parameter int TW      = 8,
   parameter int MODULUS = 11
) (
   input logic          clk,
   input logic          clear_n,
   input logic          load_n,
   input logic          cnt_en,
   input logic          carry_en,
   input logic [TW-1:0] data_in,
   input logic [TW-1:0] count,
   input logic          carry_out,
   input logic [TW-1:0] wrap_count
);

   logic armed = 1'b0;
   always_ff @(posedge clk) if (!clear_n) armed <= 1'b1;

   p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
      !clear_n |=> (count == '0 && wrap_count == '0))
      else $error("R1 clear did not zero");

   p_load_wins_r2: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load_n) |=> count == $past(data_in))
      else $error("R2 load mismatch");

   p_increment_r3: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load_n && cnt_en && carry_en) |=> count == $past(count) + 1'b1)
      else $error("R3 increment mismatch");

   p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load_n && !(cnt_en && carry_en)) |=> $stable(count))
      else $error("R4 hold mismatch");

   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load_n && cnt_en && carry_en && (&count)) |=> count == '0)
      else $error("R5 wrap mismatch");

   p_carry_gate_r6: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> (carry_en && (&count)))
      else $error("R6 carry high without cause");

   p_carry_full_r6: assert property (@(posedge clk) disable iff (!armed)
      (carry_en && (&count)) |-> carry_out)
      else $error("R6 carry missing");

   p_mod_range_r8: assert property (@(posedge clk) disable iff (!armed)
      int'(wrap_count) < MODULUS)
      else $error("R8 wrap_count out of range");

   p_mod_restart_r8: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && cnt_en && carry_en && int'(wrap_count) == MODULUS - 1)
      |=> wrap_count == '0)
      else $error("R8 modulus restart missing");

endmodule

bind casc_counter_top cnt_checker #(.TW(TOTAL_W), .MODULUS(MODULUS)) u_chk (
   .clk        (clk),
   .clear_n    (clear_n),
   .load_n     (load_n),
   .cnt_en     (cnt_en),
   .carry_en   (carry_en),
   .data_in    (data_in),
   .count      (count),
   .carry_out  (carry_out),
   .wrap_count (wrap_count)
);

// File: tb/tb_casc_counter_top.sv
`timescale 1ns/1ps
module tb_casc_counter_top;

   logic       clk = 1'b0;
   logic       clear_n, load_n, cnt_en, carry_en;
   logic [7:0] data_in;
   logic [7:0] count, wrap_count;
   logic       carry_out;
   logic [3:0] count5, wrap5;
   logic       carry5;

   always #4 clk = ~clk;

   casc_counter_top #(.STAGE_W(4), .STAGES(2), .MODULUS(11), .LOOKAHEAD(1'b0)) dut (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
      .carry_en(carry_en), .data_in(data_in), .count(count),
      .carry_out(carry_out), .wrap_count(wrap_count));

   casc_counter_top #(.STAGE_W(4), .STAGES(1), .MODULUS(5), .LOOKAHEAD(1'b1)) dut_m5 (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
      .carry_en(carry_en), .data_in(data_in[3:0]), .count(count5),
      .carry_out(carry5), .wrap_count(wrap5));

   typedef struct {
      logic [7:0] c;   logic cy;  logic [7:0] m11;
      logic [3:0] c5;  logic cy5; logic [3:0] m5;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   // reference model state
   logic [7:0] mc  = 8'h00;
   logic [7:0] m11 = 8'h00;
   logic [3:0] mc5 = 4'h0;
   logic [3:0] mm5 = 4'h0;

   task automatic check(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit clr, input bit ld, input bit ce, input bit te,
                       input logic [7:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      clear_n = clr; load_n = ld; cnt_en = ce; carry_en = te; data_in = d;
      if (!clr) begin
         mc = '0; mc5 = '0; m11 = '0; mm5 = '0;
      end else begin
         if (!ld)          begin mc = d; mc5 = d[3:0]; end
         else if (ce && te) begin mc = mc + 1'b1; mc5 = mc5 + 1'b1; end
         if (ce && te) begin
            m11 = (m11 == 8'd10) ? 8'd0 : m11 + 1'b1;
            mm5 = (mm5 == 4'd4)  ? 4'd0 : mm5 + 1'b1;
         end
      end
      e.c = mc; e.cy = te && (mc == 8'hFF); e.m11 = m11;
      e.c5 = mc5; e.cy5 = te && (mc5 == 4'hF); e.m5 = mm5; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compare just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "count",      count,             e.c);
            check(e.tag, "carry_out",  {7'd0, carry_out}, {7'd0, e.cy});
            check(e.tag, "count5",     {4'd0, count5},    {4'd0, e.c5});
            check(e.tag, "carry5",     {7'd0, carry5},    {7'd0, e.cy5});
            check("R8",  "wrap11",     wrap_count,        e.m11);
            check("R8",  "wrap5",      {4'd0, wrap5},     {4'd0, e.m5});
         end
      end
   end

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      finish_run();
   end

   initial begin
      clear_n = 1'b0; load_n = 1'b0; cnt_en = 1'b1; carry_en = 1'b1; data_in = 8'hA5;
      // R1: clear beats load and enables
      step(0, 0, 1, 1, 8'hA5, "R1");
      // R2: load beats enabled count; preset 12
      step(1, 0, 1, 1, 8'h0C, "R2");
      // R5: 13,14,15 then low nibble wraps; R7: 0x0F -> 0x10
      step(1, 1, 1, 1, 8'h00, "R3");
      step(1, 1, 1, 1, 8'h00, "R3");
      step(1, 1, 1, 1, 8'h00, "R5");
      step(1, 1, 1, 1, 8'h00, "R5/R7");
      step(1, 1, 1, 1, 8'h00, "R5");
      step(1, 1, 1, 1, 8'h00, "R5");
      // R4: either enable low holds
      step(1, 1, 0, 1, 8'h00, "R4");
      step(1, 1, 1, 0, 8'h00, "R4");
      step(1, 1, 0, 0, 8'h00, "R4");
      // R2: load with enables low
      step(1, 0, 0, 0, 8'h3B, "R2");
      // R9: run through all ones, carry high for one cycle only
      step(1, 0, 1, 1, 8'hFD, "R2");
      step(1, 1, 1, 1, 8'h00, "R9");
      step(1, 1, 1, 1, 8'h00, "R9");
      step(1, 1, 1, 1, 8'h00, "R5/R9");
      step(1, 1, 1, 1, 8'h00, "R9");
      // R1: clear beats a simultaneous load
      step(0, 0, 0, 0, 8'hFC, "R1");
      // R8: modulus sequences, load ignored by the wrap counter
      for (int i = 0; i < 10; i++) step(1, 1, 1, 1, 8'h00, "R8");
      step(1, 1, 0, 1, 8'h00, "R8");
      step(1, 0, 1, 1, 8'h40, "R8");
      for (int i = 0; i < 14; i++) step(1, 1, 1, 1, 8'h00, "R8");
      // R6: carry follows carry_en with no edge
      step(1, 0, 0, 1, 8'hFF, "R2");
      @(negedge clk);
      cnt_en = 1'b0; carry_en = 1'b1;
      #1 check("R6", "carry_out with carry_en high", {7'd0, carry_out}, 8'd1);
      carry_en = 1'b0;
      #1 check("R6", "carry_out after carry_en drop", {7'd0, carry_out}, 8'd0);
      carry_en = 1'b1;
      #1 check("R6", "carry_out after carry_en rise", {7'd0, carry_out}, 8'd1);
      step(1, 1, 1, 0, 8'h00, "R6");
      step(1, 1, 1, 1, 8'h00, "R5");
      repeat (3) @(posedge clk);
      #3;
      finish_run();
   end

endmodule